// File: doc/BRIEF.md
# Carry-Select Adder Built from Lookahead Slices

This block adds two W-bit operands and a carry-in, giving a W-bit sum and a carry-out, in a single combinational pass. The operand width is split into 8-bit slices. Inside each slice every carry is a flattened sum of products over the slice's generate and propagate terms, so no carry ripples from bit to bit within a slice.

The lowest slice receives the real carry-in. Every higher slice computes its result twice, once assuming an incoming carry of 0 and once assuming 1. A 2:1 multiplexer then picks one of the two, steered by the carry that leaves the slice below. The slice's own carry-out is selected in the same way. Across the whole width, the only serial path is this chain of multiplexers.

The block is sized for the final carry-propagate stage of a wide multiplier. With the default width of 256 it has 32 slices.

Top module: `csel_la_adder`

## Requirements
- R1: `{c_out, sum}` equals `opa + opb + c_in` taken as an unsigned (W+1)-bit value, for any operands.
- R2: An all-ones operand plus a carry-in of 1, or an all-ones operand plus 1 with a carry-in of 0, gives a sum of zero and `c_out` = 1.
- R3: The carry-in enters at bit 0. With both operands zero, `c_in` = 1 makes `sum` = 1, and `c_in` = 0 makes `sum` = 0.
- R4: Each 8-bit slice s (bits 8s+7..8s) produces the 8-bit sum of its operand bits plus the carry leaving slice s-1, or plus `c_in` when s = 0. Its carry-out is the ninth bit of that sum.
- R5: For every slice above the lowest, the carry-in-1 copy's 9-bit result is exactly one more than the carry-in-0 copy's result.
- R6: A carry made in one slice crosses every higher slice whose bits all propagate (a XOR b all ones). For example, `opa` = 2^(8k) - 1 with `opb` = 1 gives `sum` = 2^(8k).
- R7: The width W is a parameter that must be a multiple of 8, and the block has W/8 slices. A 24-bit instance meets R1.
- R8: `c_out` is the carry leaving the top slice. For example, 2^(W-1) + 2^(W-1) gives `sum` = 0 and `c_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First addend |
| opb | input | W | Second addend |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | W | Sum, low W bits |
| c_out | output | 1 | Carry out of the top bit |

## Verification
Random operands almost never make a long chain of slices in which every bit propagates, yet that chain is exactly where a wrong multiplexer steer or a wrong copy would show. The stimulus therefore builds such chains on purpose:
- operands of the form 2^(8k) - 1 plus 1, for every slice boundary k;
- all-ones operands with each carry-in value;
- alternating-bit operands whose sum is all ones.

On top of these, many random vectors are applied, and every result is compared against a behavioural wide addition.

// File: rtl/csel_la_adder.sv
module csel_la_adder #(
  parameter int W  = 256,
  parameter int SW = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out
);
  localparam int NS = W / SW;

  function automatic logic [SW:0] la_slice(input logic [SW-1:0] x, input logic [SW-1:0] y, input logic ci);
    logic [SW-1:0] g, p;
    logic [SW:0]   c;
    logic          t;
    g = x & y;
    p = x ^ y;
    c = '0;
    c[0] = ci;
    for (int i = 0; i < SW; i++) begin
      t = ci;
      for (int k = 0; k <= i; k++) t = t & p[k];
      c[i+1] = t;
      for (int j = 0; j <= i; j++) begin
        t = g[j];
        for (int k = j + 1; k <= i; k++) t = t & p[k];
        c[i+1] = c[i+1] | t;
      end
    end
    return {c[SW], p ^ c[SW-1:0]};
  endfunction

  logic [NS:0] sc;
  assign sc[0] = c_in;
  assign c_out = sc[NS];

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_sl
      logic [SW-1:0] xa, ya;
      assign xa = opa[s*SW +: SW];
      assign ya = opb[s*SW +: SW];

      if (s == 0) begin : g_lo
        logic [SW:0] r;
        assign r = la_slice(xa, ya, c_in);
        assign sum[SW-1:0] = r[SW-1:0];
        assign sc[1] = r[SW];
      end else begin : g_hi
        logic [SW:0] r0, r1;
        assign r0 = la_slice(xa, ya, 1'b0);
        assign r1 = la_slice(xa, ya, 1'b1);
        assign {sc[s+1], sum[s*SW +: SW]} = sc[s] ? r1 : r0;

        always_comb begin
          if (!$isunknown({xa, ya})) begin
            AST_COPY_STEP: assert (r1 == r0 + 1'b1) else $error("copy step"); // R5
            AST_PROP_CHAIN: assert (!(&(xa ^ ya)) || (!r0[SW] && r1[SW])) else $error("prop chain"); // R6
          end
        end
      end

      always_comb begin
        if (!$isunknown({xa, ya, sc[s]}))
          AST_SLICE_ARITH: assert ({sc[s+1], sum[s*SW +: SW]} == {1'b0, xa} + {1'b0, ya} + {{SW{1'b0}}, sc[s]}) else $error("slice arith"); // R4
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown({opa, opb, c_in}))
      AST_TOTAL_SUM: assert ({c_out, sum} == {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, c_in}) else $error("total sum"); // R1
  end
endmodule

// File: tb/sim_csel_la_adder.sv
module sim_csel_la_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 256;
  localparam int W2 = 24;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]  a = '0, b = '0, s;
  logic          ci = 1'b0, co;
  logic [W2-1:0] a2 = '0, b2 = '0, s2;
  logic          ci2 = 1'b0, co2;

  int nvec = 0, nbad = 0;

  csel_la_adder #(.W(W)) u0 (.opa(a), .opb(b), .c_in(ci), .sum(s), .c_out(co));
  csel_la_adder #(.W(W2)) u1 (.opa(a2), .opb(b2), .c_in(ci2), .sum(s2), .c_out(co2));

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] v;
    for (int i = 0; i < W/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
    logic [W:0] exp;
    @(posedge clk);
    a <= x; b <= y; ci <= c;
    @(negedge clk);
    exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    nvec++;
    if ({co, s} !== exp) begin
      nbad++;
      $display("FAIL %s got %h expected %h", tag, {co, s}, exp);
    end
  endtask

  task automatic apply24(input logic [W2-1:0] x, input logic [W2-1:0] y, input logic c);
    logic [W2:0] exp;
    @(posedge clk);
    a2 <= x; b2 <= y; ci2 <= c;
    @(negedge clk);
    exp = {1'b0, x} + {1'b0, y} + {{W2{1'b0}}, c};
    nvec++;
    if ({co2, s2} !== exp) begin
      nbad++;
      $display("FAIL R7 got %h expected %h", {co2, s2}, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    apply('0, '0, 1'b0, "R1 zero");
    apply('0, '0, 1'b1, "R3 cin only");
    apply({W{1'b1}}, '0, 1'b1, "R2 ones+cin");
    apply({W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R2 ones+1");
    apply({W{1'b1}}, {W{1'b1}}, 1'b1, "R1 max");
    apply({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b0, "R6 alternating");
    apply({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b1, "R6 alternating cin");
    apply({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, "R8 top carry");
    for (int k = 1; k < W/8; k++) begin
      apply((({{(W-1){1'b0}}, 1'b1}) << (8*k)) - 1'b1, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R6 boundary");
      apply({W{1'b1}} << (8*k), rnd() & ((({{(W-1){1'b0}}, 1'b1}) << (8*k)) - 1'b1), 1'b1, "R4 mixed");
    end
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x;
      x = rnd();
      apply(x, ~x, i[0], "R5 full propagate");
    end
    for (int i = 0; i < 2000; i++) apply(rnd(), rnd(), i[1], "R1 random");
    apply24({W2{1'b1}}, 24'd1, 1'b0);
    apply24({W2{1'b1}}, {W2{1'b1}}, 1'b1);
    for (int i = 0; i < 500; i++) apply24(W2'($urandom), W2'($urandom), i[0]);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule